// File: doc/BRIEF.md
# Dual-Length Boxcar Averager

This block smooths a stream of signed position samples by keeping two moving averages of the same input at once. One uses a short window for a fast control loop. The other uses a long window for a slow correction loop. A sample is taken on each clock edge where the strobe is high. Each average is the sum of the newest 2^K samples, shifted right arithmetically by K bits. This acts as a lowpass filter on noisy sample-by-sample data.

The block does not re-add the whole window for each sample. Each window holds a circular delay line and a running sum. For every new sample it adds the newest value and subtracts the one that leaves the window. Even a 2048-deep window therefore costs one add and one subtract per sample. A full flag for each window shows when the window holds a complete history. Until then, the missing history counts as zero. A synchronous clear restarts both windows.

Top module: `dual_boxcar_avg`

## Requirements
- R1: While reset is asserted, and right after it, both averages read 0 and both full flags are low.
- R2: One cycle after an accepted sample, `fast_avg` equals the sum of the last 32 accepted samples, shifted arithmetically right by 5. Samples not yet received count as zero.
- R3: One cycle after an accepted sample, `slow_avg` equals the sum of the last 2048 accepted samples, shifted arithmetically right by 11. Samples not yet received count as zero.
- R4: `fast_full` goes high in the cycle after the 32nd accepted sample since reset or clear, and not before. It then stays high until a clear.
- R5: `slow_full` goes high in the cycle after the 2048th accepted sample since reset or clear, and not before. It then stays high until a clear.
- R6: In a cycle where `smp_valid` is low and `clr` is low, both averages and both flags keep their values.
- R7: When `clr` is high at an edge, both averages read 0 and both flags are low in the next cycle, and the fill count restarts. A sample strobed in the same cycle is discarded, because the clear has priority.
- R8: The averages are rounded toward negative infinity. For example, a single sample of -1 gives -1 on both outputs, and a single sample of +31 gives 0 on the fast output.
- R9: There is no overflow in the running sums. A full window of the most positive input value returns that value exactly, and a full window of the most negative input value does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of both windows; has priority over `smp_valid` |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed two's-complement sample |
| fast_avg | output | DATA_W | Signed short-window average |
| fast_full | output | 1 | Short window holds a complete history |
| slow_avg | output | DATA_W | Signed long-window average |
| slow_full | output | 1 | Long window holds a complete history |

## Verification
Two events can coincide at one clock edge: a clear, and the strobe of a sample. The bench drives both high at the same edge, first after the short window has filled. It checks that both outputs and flags read zero in the next cycle, and that the next sample alone sets the averages. Another coincidence is the window's first wrap, which happens in the same cycle as the full flag rises. The bench judges it at the 2048th and 2049th sample: the first subtraction of an old sample must land exactly where the bench's own model of the window expects it.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

   // Width of the running sum for a window of 2**log2n samples.
   function automatic int acc_width(input int data_w, input int log2n);
      return data_w + log2n;
   endfunction

   // Pointer width; a single-entry ring still needs one bit.
   function automatic int ptr_width(input int log2n);
      return (log2n < 1) ? 1 : log2n;
   endfunction

endpackage

// File: rtl/boxcar_ring.sv
module boxcar_ring #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] oldest
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] ptr;

   // Async read of the slot that is about to be overwritten.
   assign oldest = mem[ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (clr)
         ptr <= '0;
      else if (wr_en)
         ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr)
         mem[ptr] <= wr_data;
   end
endmodule

// File: rtl/boxcar_fill.sv
module boxcar_fill #(
   parameter int LOG2N = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);
   localparam int CNT_W = LOG2N + 1;
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << LOG2N;

   logic [CNT_W-1:0] count;

   assign full = (count == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && !full)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/boxcar_window.sv
module boxcar_window
   import boxcar_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LOG2N  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic [DATA_W-1:0] avg,
   output logic              full
);
   localparam int ACC_W = acc_width(DATA_W, LOG2N);

   generate
      if (LOG2N == 0) begin : g_single
         // One-sample window: the average is the last sample.
         logic [DATA_W-1:0] last_q;
         logic              seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= '0;
               seen_q <= 1'b0;
            end else if (clr) begin
               last_q <= '0;
               seen_q <= 1'b0;
            end else if (in_valid) begin
               last_q <= in_data;
               seen_q <= 1'b1;
            end
         end
         assign avg  = last_q;
         assign full = seen_q;
      end else begin : g_ring
         logic [DATA_W-1:0]       old_smp;
         logic                    fill_done;
         logic signed [ACC_W-1:0] sum_q;
         logic signed [ACC_W-1:0] add_term;
         logic signed [ACC_W-1:0] sub_term;
         logic signed [ACC_W-1:0] shifted;

         boxcar_ring #(.DATA_W(DATA_W), .ADDR_W(ptr_width(LOG2N))) u_ring (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .wr_en   (in_valid),
            .wr_data (in_data),
            .oldest  (old_smp)
         );

         boxcar_fill #(.LOG2N(LOG2N)) u_fill (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (in_valid),
            .full  (fill_done)
         );

         // Before the ring is full the leaving slot is stale: it counts as zero.
         assign add_term = ACC_W'($signed(in_data));
         assign sub_term = fill_done ? ACC_W'($signed(old_smp)) : '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sum_q <= '0;
            else if (clr)
               sum_q <= '0;
            else if (in_valid)
               sum_q <= sum_q + add_term - sub_term;
         end

         assign shifted = sum_q >>> LOG2N;
         assign avg     = shifted[DATA_W-1:0];
         assign full    = fill_done;
      end
   endgenerate
endmodule

// File: rtl/dual_boxcar_avg.sv
module dual_boxcar_avg #(
   parameter int DATA_W     = 16,
   parameter int FAST_LOG2N = 5,
   parameter int SLOW_LOG2N = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_data,
   output logic [DATA_W-1:0] fast_avg,
   output logic              fast_full,
   output logic [DATA_W-1:0] slow_avg,
   output logic              slow_full
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dual_boxcar_avg: DATA_W must be at least 2");
      end
      if (FAST_LOG2N < 0 || FAST_LOG2N > SLOW_LOG2N) begin : g_bad_order
         $error("dual_boxcar_avg: need 0 <= FAST_LOG2N <= SLOW_LOG2N");
      end
      if (SLOW_LOG2N > 16) begin : g_bad_depth
         $error("dual_boxcar_avg: SLOW_LOG2N too large");
      end
   endgenerate

   boxcar_window #(.DATA_W(DATA_W), .LOG2N(FAST_LOG2N)) u_fast (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_valid (smp_valid),
      .in_data  (smp_data),
      .avg      (fast_avg),
      .full     (fast_full)
   );

   boxcar_window #(.DATA_W(DATA_W), .LOG2N(SLOW_LOG2N)) u_slow (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_valid (smp_valid),
      .in_data  (smp_data),
      .avg      (slow_avg),
      .full     (slow_full)
   );
endmodule

// File: rtl/dual_boxcar_avg_chk.sv
module dual_boxcar_avg_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              smp_valid,
   input logic [DATA_W-1:0] fast_avg,
   input logic              fast_full,
   input logic [DATA_W-1:0] slow_avg,
   input logic              slow_full
);
   // R7: a clear empties both windows by the next cycle
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fast_avg == '0 && slow_avg == '0 && !fast_full && !slow_full));

   // R6: an idle cycle changes nothing
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !clr) |=> ($stable(fast_avg) && $stable(slow_avg)
                                && $stable(fast_full) && $stable(slow_full)));

   // R4: the short flag stays high until a clear
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fast_full && !clr) |=> fast_full);

   // R5: the long flag stays high until a clear
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_full && !clr) |=> slow_full);

   // R5: the long window cannot be complete before the short one
   a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
      slow_full |-> fast_full);

   // R4: the short flag only rises on an accepted sample
   a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_full) |-> ($past(smp_valid) && !$past(clr)));

   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n)
         a_r1_reset: assert (fast_avg == '0 && slow_avg == '0 && !fast_full && !slow_full);
   end
endmodule

bind dual_boxcar_avg dual_boxcar_avg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .smp_valid (smp_valid),
   .fast_avg  (fast_avg),
   .fast_full (fast_full),
   .slow_avg  (slow_avg),
   .slow_full (slow_full)
);

// File: tb/dual_boxcar_avg_test.sv
`timescale 1ns/1ps
module dual_boxcar_avg_test;
   localparam int W     = 16;
   localparam int FL    = 5;
   localparam int SL    = 11;
   localparam int FN    = 1 << FL;
   localparam int SN    = 1 << SL;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          smp_valid = 1'b0;
   logic [W-1:0]  smp_data = '0;
   logic [W-1:0]  fast_avg, slow_avg;
   logic          fast_full, slow_full;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model of the window history
   logic signed [W-1:0] hist [SN];
   int wr_idx = 0;
   int seen   = 0;

   always #2.5 clk = ~clk;

   dual_boxcar_avg #(.DATA_W(W), .FAST_LOG2N(FL), .SLOW_LOG2N(SL)) uut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_valid(smp_valid),
      .smp_data(smp_data), .fast_avg(fast_avg), .fast_full(fast_full),
      .slow_avg(slow_avg), .slow_full(slow_full)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model_avg(input int log2n);
      longint s = 0;
      int n = 1 << log2n;
      int k_max = (seen < n) ? seen : n;
      for (int k = 0; k < k_max; k++)
         s += longint'(hist[(wr_idx - 1 - k + SN) % SN]);
      return s >>> log2n;
   endfunction

   function automatic bit model_full(input int log2n);
      return seen >= (1 << log2n);
   endfunction

   task automatic model_clear();
      wr_idx = 0;
      seen   = 0;
   endtask

   // one clock: drive, model, then check away from the edge
   task automatic step(input bit v, input bit c, input logic signed [W-1:0] d,
                       input bit do_chk);
      @(negedge clk);
      smp_valid = v;
      clr       = c;
      smp_data  = d;
      @(posedge clk);
      if (c) model_clear();
      else if (v) begin
         hist[wr_idx] = d;
         wr_idx = (wr_idx + 1) % SN;
         seen++;
      end
      #1;
      if (do_chk) begin
         check("R2 fast avg", longint'($signed(fast_avg)), model_avg(FL));
         check("R3 slow avg", longint'($signed(slow_avg)), model_avg(SL));
         check("R4 fast full", longint'(fast_full), longint'(model_full(FL)));
         check("R5 slow full", longint'(slow_full), longint'(model_full(SL)));
      end
   endtask

   initial begin
      #900000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pf, ps;
      logic pff, psf;
      void'($urandom(32'h5EED_B0C5));

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1 fast avg", longint'($signed(fast_avg)), 0);
      check("R1 slow avg", longint'($signed(slow_avg)), 0);
      check("R1 flags", longint'({fast_full, slow_full}), 0);
      @(negedge clk) rst_n = 1'b1;

      // R8: rounding toward negative infinity
      step(1, 0, -16'sd1, 0);
      check("R8 fast -1", longint'($signed(fast_avg)), -1);
      check("R8 slow -1", longint'($signed(slow_avg)), -1);
      step(0, 1, '0, 0);
      step(1, 0, 16'sd31, 0);
      check("R8 fast +31", longint'($signed(fast_avg)), 0);
      step(0, 1, '0, 0);

      // R2, R4: fill the short window with random data
      for (int i = 0; i < 40; i++) begin
         step(1, 0, W'($urandom), 1);
         if (seen == FN - 1) check("R4 not full at 31", longint'(fast_full), 0);
         if (seen == FN) check("R4 full at 32", longint'(fast_full), 1);
      end

      // R6: idle cycles keep state
      pf = fast_avg; ps = slow_avg; pff = fast_full; psf = slow_full;
      for (int i = 0; i < 5; i++) step(0, 0, W'($urandom), 0);
      check("R6 fast hold", longint'(fast_avg), longint'(pf));
      check("R6 slow hold", longint'(slow_avg), longint'(ps));
      check("R6 flags hold", longint'({fast_full, slow_full}), longint'({pff, psf}));

      // R7: clear and sample in the same cycle, clear wins
      step(1, 1, 16'sd1000, 0);
      check("R7 fast zero", longint'($signed(fast_avg)), 0);
      check("R7 slow zero", longint'($signed(slow_avg)), 0);
      check("R7 flags low", longint'({fast_full, slow_full}), 0);
      step(1, 0, 16'sd3200, 0);
      check("R7 fresh fast", longint'($signed(fast_avg)), 100);

      // R3, R5: fill the long window through its first wrap, random gaps
      while (seen < SN + 80) begin
         bit v = ($urandom % 5) != 0;
         step(v, 0, W'($urandom), (seen % 16 == 0) || (seen >= SN - 2));
         if (v && seen == SN - 1) check("R5 not full at 2047", longint'(slow_full), 0);
         if (v && seen == SN) check("R5 full at 2048", longint'(slow_full), 1);
      end

      // R9: extreme values, no overflow
      for (int i = 0; i < SN; i++) step(1, 0, 16'sh7FFF, 0);
      check("R9 fast max", longint'($signed(fast_avg)), 32767);
      check("R9 slow max", longint'($signed(slow_avg)), 32767);
      for (int i = 0; i < SN; i++) step(1, 0, 16'sh8000, 0);
      check("R9 fast min", longint'($signed(fast_avg)), -32768);
      check("R9 slow min", longint'($signed(slow_avg)), -32768);

      // mixed random tail with sporadic clears
      for (int i = 0; i < 300; i++)
         step(($urandom % 3) != 0, ($urandom % 97) == 0, W'($urandom), 1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule